// File: doc/BRIEF.md
# Slot-Bitmap Receive Buffer Allocator

This block hands out space in a single circular receive buffer for incoming RPC payloads. The buffer is split into fixed-size slots (64 bytes by default), and one occupancy bit is kept per slot. An allocation request carries the payload size in bytes. The block either returns the slot index where the payload should start and moves its head pointer forward by the number of slots the payload needs, or it rejects the request with a NACK when there is not enough room. A payload that spans more than one slot also raises a request for a reassembly entry, because it will arrive as several packets.

Space comes back through free requests, each carrying a starting slot and a byte length. Frees may arrive in any order. The covered bits are cleared at once, and the tail pointer then jumps over every leading cleared slot, stopping at the first slot that is still held. When the head has caught up with the tail, the buffer counts as full. A background scrubber then walks the occupancy bits once, starting at the tail, and reports the first run of free slots that fragmentation has left behind, without sitting on the allocation or free paths.

The buffer is meant to be sized from the expected peak queue depth rather than from the number of remote clients. For example, ten times a mean depth of sixteen RPCs at 512 bytes each needs about 81 KB, which is 1280 slots of 64 bytes.

Top module: `rxslot_alloc`

## Requirements
- R1: After reset, head and tail are slot 0, `used_slots` is 0, `buf_full` is 0, and `alloc_ok`, `alloc_nack`, `alloc_multi`, `free_err` and `scrub_done` are all 0.
- R2: An accepted allocation of B bytes takes n = ceil(B / SLOT_BYTES) slots. In the cycle after the request, `alloc_ok` is 1 and `alloc_slot` is the old head. The head moves by n modulo SLOTS, and `used_slots` grows by n.
- R3: A request is NACKed, with head and `used_slots` unchanged, when B is 0, when n exceeds the free room SLOTS − `used_slots`, or when `buf_full` is 1. `alloc_nack` is pulsed in the next cycle.
- R4: `alloc_multi` pulses together with `alloc_ok` exactly when the accepted allocation uses more than one slot.
- R5: A free of L bytes at slot s clears the ceil(L / SLOT_BYTES) slots from s, wrapping modulo SLOTS. If L is 0, if the span exceeds SLOTS, or if any covered slot is not allocated, `free_err` pulses in the next cycle and no occupancy bit changes.
- R6: One cycle after the bits are cleared, the tail moves past every consecutive cleared slot, starting at the tail. It stops at the first allocated slot or at the head, and `used_slots` drops by the same amount.
- R7: Freeing slots that lie beyond a still-allocated oldest slot leaves the tail and `used_slots` unchanged. Freeing the oldest slot later moves the tail past all the cleared slots at once.
- R8: Head, tail, allocation spans and free spans wrap modulo SLOTS. `buf_full` is 1 exactly when `used_slots` equals SLOTS, so a full buffer and an empty buffer are told apart even though head equals tail in both.
- R9: An allocation and a valid free in the same cycle are both carried out. Room for the allocation is judged before the free reclaims anything.
- R10: While `buf_full` is 1, the scrubber scans all SLOTS bits once, starting at the tail. It then raises `scrub_done`, with `scrub_slot` set to the start of the first free run and `scrub_len` set to its length (0 if there is none). `scrub_done` drops once the buffer is no longer full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Allocation request strobe |
| alloc_bytes | input | BYTES_W | Payload size in bytes |
| free_req | input | 1 | Free request strobe |
| free_slot | input | $clog2(SLOTS) | First slot to free |
| free_bytes | input | BYTES_W | Length to free in bytes |
| alloc_ok | output | 1 | Allocation accepted (one cycle after the request) |
| alloc_nack | output | 1 | Allocation rejected (one cycle after the request) |
| alloc_slot | output | $clog2(SLOTS) | Base slot of the accepted allocation |
| alloc_multi | output | 1 | Reassembly entry needed (multi-slot payload) |
| free_err | output | 1 | Free request rejected |
| buf_full | output | 1 | Head has met tail with every slot in use |
| used_slots | output | $clog2(SLOTS+1) | Slots from tail to head |
| head_slot | output | $clog2(SLOTS) | Next slot to allocate |
| tail_slot | output | $clog2(SLOTS) | Oldest slot not yet reclaimed |
| scrub_done | output | 1 | Scrub result valid |
| scrub_slot | output | $clog2(SLOTS) | Start of the first free run found |
| scrub_len | output | $clog2(SLOTS+1) | Length of that run in slots |

## Verification
The bench builds the block with SLOTS = 16, SLOT_BYTES = 64 and BYTES_W = 16. With only sixteen slots, a handful of requests fills the buffer, wraps both pointers past the end and leaves a fragmented free run inside a full buffer. This exercises the scrubber and the same-cycle allocate and free case within a few dozen cycles. The 64-byte slot makes the rounding cases (1, 64, 100, 1088 bytes) easy to hit exactly.

// File: rtl/rxslot_pkg.sv
// Package: shared types and ring-index helpers for the slot allocator.
// Assumes every index passed in is already below the ring size n.
package rxslot_pkg;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_SCAN = 2'd1,
        SC_DONE = 2'd2
    } scrub_st_e;

    // Index a+b on a ring of n entries.
    function automatic int ring_add(input int a, input int b, input int n);
        return (a + b) % n;
    endfunction

    // Distance from base forward to i on a ring of n entries.
    function automatic int ring_off(input int i, input int base, input int n);
        return (i - base + n) % n;
    endfunction

endpackage

// File: rtl/rxslot_span.sv
// Module: converts a byte length to a slot count, rounding up.
// Flags a zero length and a count above SLOTS. When the count is above
// SLOTS, the cnt output is 0 and must not be used.
module rxslot_span #(
    parameter int SLOTS      = 32,
    parameter int SLOT_BYTES = 64,
    parameter int BYTES_W    = 16
) (
    input  logic [BYTES_W-1:0]          bytes,
    output logic [$clog2(SLOTS+1)-1:0]  cnt,
    output logic                        zero,
    output logic                        over
);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int SHIFT = $clog2(SLOT_BYTES);

    logic [BYTES_W:0] padded;
    logic [BYTES_W:0] total;

    // Round the byte count up to whole slots.
    always_comb begin
        padded = {1'b0, bytes} + (BYTES_W + 1)'(SLOT_BYTES - 1);
        total  = padded >> SHIFT;
        zero   = (total == '0);
        over   = (total > (BYTES_W + 1)'(SLOTS));
        cnt    = over ? '0 : CNT_W'(total);
    end

endmodule

// File: rtl/rxslot_tailscan.sv
// Module: counts the cleared slots that lie in a row starting at the tail.
// The count is capped at the number of slots in use. The tail may advance
// by that count. Assumes that slots outside the in-use window are always clear.
module rxslot_tailscan
    import rxslot_pkg::*;
#(
    parameter int SLOTS = 32
) (
    input  logic [SLOTS-1:0]            bits,
    input  logic [$clog2(SLOTS)-1:0]    tail,
    input  logic [$clog2(SLOTS+1)-1:0]  occ,
    output logic [$clog2(SLOTS+1)-1:0]  adv
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic stop;

    // Walk forward from the tail until a held slot or the head is reached.
    always_comb begin
        adv  = '0;
        stop = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!stop && (i < int'(occ)) && !bits[ring_add(int'(tail), i, SLOTS)])
                adv = adv + CNT_W'(1);
            else
                stop = 1'b1;
        end
    end

endmodule

// File: rtl/rxslot_scrub.sv
// Module: background scrubber. While the buffer is full, it scans every
// occupancy bit once, one per cycle, starting at the tail captured when the
// scan begins, and holds the first run of cleared slots it met. The result is
// advisory: frees that land during a scan may or may not be seen.
module rxslot_scrub
    import rxslot_pkg::*;
#(
    parameter int SLOTS = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        full,
    input  logic [SLOTS-1:0]            bits,
    input  logic [$clog2(SLOTS)-1:0]    tail,
    output logic                        done,
    output logic [$clog2(SLOTS)-1:0]    run_slot,
    output logic [$clog2(SLOTS+1)-1:0]  run_len
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);

    scrub_st_e          st;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   start;
    logic [IDX_W-1:0]   pos;
    logic               in_run;
    logic               closed;

    // Slot examined in this scan step.
    always_comb pos = IDX_W'(ring_add(int'(start), int'(cnt), SLOTS));

    // Scan state machine: idle until full, one slot per cycle, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n || !full) begin
            st       <= SC_IDLE;
            cnt      <= '0;
            start    <= '0;
            in_run   <= 1'b0;
            closed   <= 1'b0;
            run_slot <= '0;
            run_len  <= '0;
        end else begin
            case (st)
                SC_IDLE: begin
                    st       <= SC_SCAN;
                    cnt      <= '0;
                    start    <= tail;
                    in_run   <= 1'b0;
                    closed   <= 1'b0;
                    run_slot <= tail;
                    run_len  <= '0;
                end
                SC_SCAN: begin
                    if (!closed) begin
                        if (!bits[pos]) begin
                            if (!in_run) begin
                                run_slot <= pos;
                                run_len  <= CNT_W'(1);
                                in_run   <= 1'b1;
                            end else begin
                                run_len  <= run_len + CNT_W'(1);
                            end
                        end else if (in_run) begin
                            closed <= 1'b1;
                        end
                    end
                    if (cnt == CNT_W'(SLOTS - 1)) st <= SC_DONE;
                    else                          cnt <= cnt + CNT_W'(1);
                end
                default: st <= SC_DONE;
            endcase
        end
    end

    assign done = (st == SC_DONE);

    // R10: a result never outlives the full condition by more than one edge.
    p_scrub_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !full |=> !done);

    // R10: the reported run never exceeds the ring.
    p_scrub_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len <= CNT_W'(SLOTS)));

endmodule

// File: rtl/rxslot_alloc.sv
// Module: top of the slot-bitmap receive buffer allocator.
// Keeps head, tail, an in-use count and one occupancy bit per slot.
// Allocations are judged on the current state. Frees are checked against the
// current bits. The tail reclaims cleared slots one cycle after they clear.
// Assumes at most one allocation and one free are presented per cycle.
module rxslot_alloc
    import rxslot_pkg::*;
#(
    parameter int SLOTS      = 32,
    parameter int SLOT_BYTES = 64,
    parameter int BYTES_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_req,
    input  logic [BYTES_W-1:0]          alloc_bytes,
    input  logic                        free_req,
    input  logic [$clog2(SLOTS)-1:0]    free_slot,
    input  logic [BYTES_W-1:0]          free_bytes,
    output logic                        alloc_ok,
    output logic                        alloc_nack,
    output logic [$clog2(SLOTS)-1:0]    alloc_slot,
    output logic                        alloc_multi,
    output logic                        free_err,
    output logic                        buf_full,
    output logic [$clog2(SLOTS+1)-1:0]  used_slots,
    output logic [$clog2(SLOTS)-1:0]    head_slot,
    output logic [$clog2(SLOTS)-1:0]    tail_slot,
    output logic                        scrub_done,
    output logic [$clog2(SLOTS)-1:0]    scrub_slot,
    output logic [$clog2(SLOTS+1)-1:0]  scrub_len
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [SLOTS-1:0]   bits_q, bits_d;
    logic [IDX_W-1:0]   head_q, tail_q;
    logic [CNT_W-1:0]   occ_q;
    logic [CNT_W-1:0]   a_n, f_n, adv;
    logic               a_zero, a_over, f_zero, f_over;
    logic               alloc_go, free_bad, free_go, full;
    logic [CNT_W:0]     room_need;

    rxslot_span #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .BYTES_W(BYTES_W)) u_aspan (
        .bytes(alloc_bytes), .cnt(a_n), .zero(a_zero), .over(a_over));

    rxslot_span #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .BYTES_W(BYTES_W)) u_fspan (
        .bytes(free_bytes), .cnt(f_n), .zero(f_zero), .over(f_over));

    rxslot_tailscan #(.SLOTS(SLOTS)) u_tscan (
        .bits(bits_q), .tail(tail_q), .occ(occ_q), .adv(adv));

    rxslot_scrub #(.SLOTS(SLOTS)) u_scrub (
        .clk(clk), .rst_n(rst_n), .full(full), .bits(bits_q), .tail(tail_q),
        .done(scrub_done), .run_slot(scrub_slot), .run_len(scrub_len));

    // Full when the in-use window covers the whole ring.
    always_comb full = (occ_q == CNT_W'(SLOTS));

    // Decide both requests on the current state and build the next bit vector.
    always_comb begin
        room_need = {1'b0, occ_q} + {1'b0, a_n};
        alloc_go  = alloc_req && !a_zero && !a_over && !full &&
                    (room_need <= (CNT_W + 1)'(SLOTS));
        free_bad  = f_zero || f_over || (int'(free_slot) >= SLOTS);
        for (int i = 0; i < SLOTS; i++) begin
            if ((ring_off(i, int'(free_slot), SLOTS) < int'(f_n)) && !bits_q[i])
                free_bad = 1'b1;
        end
        free_go = free_req && !free_bad;
        bits_d  = bits_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (free_go && (ring_off(i, int'(free_slot), SLOTS) < int'(f_n)))
                bits_d[i] = 1'b0;
            if (alloc_go && (ring_off(i, int'(head_q), SLOTS) < int'(a_n)))
                bits_d[i] = 1'b1;
        end
    end

    // State and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q      <= '0;
            head_q      <= '0;
            tail_q      <= '0;
            occ_q       <= '0;
            alloc_ok    <= 1'b0;
            alloc_nack  <= 1'b0;
            alloc_slot  <= '0;
            alloc_multi <= 1'b0;
            free_err    <= 1'b0;
        end else begin
            bits_q      <= bits_d;
            tail_q      <= IDX_W'(ring_add(int'(tail_q), int'(adv), SLOTS));
            occ_q       <= occ_q + (alloc_go ? a_n : '0) - adv;
            alloc_ok    <= alloc_go;
            alloc_nack  <= alloc_req && !alloc_go;
            alloc_multi <= alloc_go && (a_n > CNT_W'(1));
            free_err    <= free_req && free_bad;
            if (alloc_go) begin
                head_q     <= IDX_W'(ring_add(int'(head_q), int'(a_n), SLOTS));
                alloc_slot <= head_q;
            end
        end
    end

    assign buf_full   = full;
    assign used_slots = occ_q;
    assign head_slot  = head_q;
    assign tail_slot  = tail_q;

    // R3: a request seen while full is always rejected.
    p_nack_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_req) |=> alloc_nack);

    // R2: accept and reject never answer the same request.
    p_ok_nack_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_ok && alloc_nack));

    // R4: a reassembly request only comes with an accepted allocation.
    p_multi_needs_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_multi |-> alloc_ok);

    // R6: the tail never passes a slot that is still allocated.
    p_tail_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q != '0 && bits_q[tail_q]) |=> (tail_q == $past(tail_q)));

    // R8: the in-use count never exceeds the ring.
    p_used_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        used_slots <= CNT_W'(SLOTS));

    // R1: the reset state is empty and quiet.
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (occ_q == '0 && !alloc_ok && !free_err));

endmodule

// File: tb/rxslot_alloc_tb.sv
// Directed bench for rxslot_alloc: one task per scenario.
module rxslot_alloc_tb;
    localparam int SLOTS      = 16;
    localparam int SLOT_BYTES = 64;
    localparam int BYTES_W    = 16;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = $clog2(SLOTS);
    localparam int CNT_W      = $clog2(SLOTS + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               alloc_req = 1'b0;
    logic [BYTES_W-1:0] alloc_bytes = '0;
    logic               free_req = 1'b0;
    logic [IDX_W-1:0]   free_slot = '0;
    logic [BYTES_W-1:0] free_bytes = '0;
    logic               alloc_ok, alloc_nack, alloc_multi, free_err, buf_full, scrub_done;
    logic [IDX_W-1:0]   alloc_slot, head_slot, tail_slot, scrub_slot;
    logic [CNT_W-1:0]   used_slots, scrub_len;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxslot_alloc #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .BYTES_W(BYTES_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_bytes(alloc_bytes),
        .free_req(free_req), .free_slot(free_slot), .free_bytes(free_bytes),
        .alloc_ok(alloc_ok), .alloc_nack(alloc_nack), .alloc_slot(alloc_slot),
        .alloc_multi(alloc_multi), .free_err(free_err), .buf_full(buf_full),
        .used_slots(used_slots), .head_slot(head_slot), .tail_slot(tail_slot),
        .scrub_done(scrub_done), .scrub_slot(scrub_slot), .scrub_len(scrub_len));

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One request cycle; outputs are sampled at the next falling edge.
    task automatic op(input bit a, input int ab, input bit f, input int fs, input int fb);
        @(negedge clk);
        alloc_req   = a;
        alloc_bytes = BYTES_W'(ab);
        free_req    = f;
        free_slot   = IDX_W'(fs);
        free_bytes  = BYTES_W'(fb);
        @(negedge clk);
        alloc_req = 1'b0;
        free_req  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 used", int'(used_slots), 0);
        check("R1 head", int'(head_slot), 0);
        check("R1 tail", int'(tail_slot), 0);
        check("R1 full", int'(buf_full), 0);
        check("R1 quiet", int'({alloc_ok, alloc_nack, alloc_multi, free_err, scrub_done}), 0);
    endtask

    task automatic t_alloc();
        op(1, 100, 0, 0, 0);
        check("R2 ok 100B", int'(alloc_ok), 1);
        check("R2 slot 100B", int'(alloc_slot), 0);
        check("R4 multi 100B", int'(alloc_multi), 1);
        check("R2 head 100B", int'(head_slot), 2);
        op(1, 64, 0, 0, 0);
        check("R2 slot 64B", int'(alloc_slot), 2);
        check("R4 single 64B", int'(alloc_multi), 0);
        op(1, 1, 0, 0, 0);
        check("R2 slot 1B", int'(alloc_slot), 3);
        check("R2 used", int'(used_slots), 4);
        check("R2 head", int'(head_slot), 4);
    endtask

    task automatic t_out_of_order();
        op(0, 0, 1, 2, 64);
        check("R5 free ok", int'(free_err), 0);
        idle(1);
        check("R7 tail held", int'(tail_slot), 0);
        check("R7 used held", int'(used_slots), 4);
        op(0, 0, 1, 0, 128);
        idle(1);
        check("R6 tail jump", int'(tail_slot), 3);
        check("R6 used drop", int'(used_slots), 1);
        op(0, 0, 1, 3, 1);
        idle(1);
        check("R6 tail at head", int'(tail_slot), 4);
        check("R6 empty", int'(used_slots), 0);
    endtask

    task automatic t_free_err();
        op(0, 0, 1, 5, 64);
        check("R5 err unallocated", int'(free_err), 1);
        idle(1);
        check("R5 err used", int'(used_slots), 0);
        check("R5 err tail", int'(tail_slot), 4);
        op(0, 0, 1, 4, 0);
        check("R5 err zero len", int'(free_err), 1);
    endtask

    task automatic t_nack();
        op(1, 0, 0, 0, 0);
        check("R3 nack zero", int'(alloc_nack), 1);
        check("R3 head kept", int'(head_slot), 4);
        op(1, 17 * 64, 0, 0, 0);
        check("R3 nack too big", int'(alloc_nack), 1);
        check("R3 used kept", int'(used_slots), 0);
    endtask

    task automatic t_wrap_full_scrub();
        op(1, 640, 0, 0, 0);
        check("R8 slot A", int'(alloc_slot), 4);
        op(1, 256, 0, 0, 0);
        check("R8 slot B", int'(alloc_slot), 14);
        check("R8 head wrap", int'(head_slot), 2);
        op(0, 0, 1, 14, 256);
        check("R8 free across end", int'(free_err), 0);
        idle(1);
        check("R7 tail behind A", int'(tail_slot), 4);
        op(1, 192, 0, 0, 0);
        check("R3 nack no room", int'(alloc_nack), 1);
        op(1, 128, 0, 0, 0);
        check("R8 slot C", int'(alloc_slot), 2);
        check("R8 full", int'(buf_full), 1);
        check("R8 used full", int'(used_slots), 16);
        op(1, 64, 0, 0, 0);
        check("R3 nack full", int'(alloc_nack), 1);
        for (int k = 0; k < 40 && !scrub_done; k++) @(negedge clk);
        check("R10 done", int'(scrub_done), 1);
        check("R10 run slot", int'(scrub_slot), 14);
        check("R10 run len", int'(scrub_len), 4);
    endtask

    task automatic t_same_cycle();
        op(1, 64, 1, 4, 640);
        check("R9 nack judged before free", int'(alloc_nack), 1);
        check("R9 free accepted", int'(free_err), 0);
        idle(2);
        check("R9 tail", int'(tail_slot), 2);
        check("R9 used", int'(used_slots), 2);
        check("R10 cleared", int'(scrub_done), 0);
        op(1, 64, 1, 2, 128);
        check("R9 alloc ok", int'(alloc_ok), 1);
        check("R9 alloc slot", int'(alloc_slot), 4);
        check("R9 free ok", int'(free_err), 0);
        idle(1);
        check("R9 tail after", int'(tail_slot), 4);
        check("R9 used after", int'(used_slots), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alloc();
        t_out_of_order();
        t_free_err();
        t_nack();
        t_wrap_full_scrub();
        t_same_cycle();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule